// File: doc/BRIEF.md
# Power-Down Controller with Alarm Wake

This block sequences the power states of a processor core. Software asks for a power-down or a standby through single-cycle request strobes in the core clock domain. The request, together with its alarm delay and stabilisation length, crosses into an always-on slow clock domain through a toggle handshake. From then on the sequencer runs entirely on the slow clock, so it keeps working while the core oscillator is stopped.

For a power-down, the sequencer waits until the core reports idle. It then removes the core clock enable and turns the oscillator enable off. A down-counter loaded with the alarm delay runs on the slow clock. When it expires, or when an enabled external wake event arrives, the oscillator enable returns at once. The core clock enable comes back only after a stabilisation count has elapsed. A sticky wake-cause pair records what ended the power-down, and stays set until software clears it.

A standby request halts the CPU while leaving both clocks running. An interrupt removes the halt combinationally, in the same cycle, and the sequencer then returns to run.

Top module: `pdc_top`

## Requirements
- R1: After reset, clkEn=1, oscEn=1, cpuHalt=0, causeAlarm=0, causeExt=0 and reqBusy=0.
- R2: A power-down accepted while coreIdle=1, with alarmDelay=D>0 and stableTicks=S>0, holds oscEn low for exactly D slow-clock cycles. It holds clkEn low for exactly D+S slow-clock cycles, and sets causeAlarm.
- R3: While coreIdle=0, a pending power-down leaves clkEn and oscEn high. Once coreIdle rises, the sequence of R2 runs unchanged.
- R4: alarmDelay=0 disables alarm wake, so power-down lasts until a synchronised extWake=1 with wakeEnable=1. That wake sets causeExt and leaves causeAlarm clear, and clkEn stays low S cycles longer than oscEn.
- R5: extWake with wakeEnable=0 has no effect: the power-down length stays D and causeExt stays 0.
- R6: causeAlarm and causeExt stay set across later runs until clrCause is held high, which clears both.
- R7: stableTicks=0 selects the parameter DEF_STABLE (default 1024) as the stabilisation length.
- R8: A standby request sets cpuHalt=1 with clkEn=1 and oscEn=1. irq=1 drops cpuHalt in the same cycle, and the block returns to run with cpuHalt=0 after irq falls.
- R9: reqBusy rises on the core-clock edge that accepts a request and falls when the slow side acknowledges. A request strobe while reqBusy=1 is ignored; its new alarmDelay is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Core clock (request side) |
| lpClk | input | 1 | Always-on slow clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdGo | input | 1 | Power-down request strobe (sysClk) |
| sbGo | input | 1 | Standby request strobe (sysClk) |
| alarmDelay | input | 32 | Alarm delay in slow ticks, 0 = alarm off |
| stableTicks | input | 16 | Stabilisation length, 0 = DEF_STABLE |
| wakeEnable | input | 1 | Enables external wake |
| coreIdle | input | 1 | Core has no bus cycle in progress |
| extWake | input | 1 | Asynchronous external wake level |
| irq | input | 1 | Interrupt ending standby |
| clrCause | input | 1 | Level clear of the wake-cause bits |
| reqBusy | output | 1 | Request handshake in flight |
| clkEn | output | 1 | Core clock gate enable |
| oscEn | output | 1 | Core oscillator enable |
| cpuHalt | output | 1 | CPU held idle in standby |
| causeAlarm | output | 1 | Sticky: alarm ended power-down |
| causeExt | output | 1 | Sticky: external event ended power-down |

## Verification
The assertions assume several properties of the inputs. alarmDelay and stableTicks stay put while a request is in flight. coreIdle, wakeEnable and clrCause change slowly compared with the slow clock. irq stays high long enough to be synchronised. The stimulus only changes these inputs on core-clock falling edges while reqBusy is low. It holds every level input for several slow cycles, and it keeps irq high until the sequencer has returned to run. extWake is driven low before each new request, so a wake left over from a previous run cannot end the next one.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STANDBY,
    ST_ENTER_PD,
    ST_POWERDOWN,
    ST_WAIT_STABLE
  } pwrState_e;

  typedef struct packed {
    logic loadAll;
    logic decAlarm;
    logic loadStable;
    logic decStable;
    logic setAlarm;
    logic setExt;
  } pdcStrobe_t;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i] <= '0;
      else       chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdc_datapath.sv
module pdc_datapath
  import pdc_pkg::*;
#(
  parameter int ALARM_W     = 32,
  parameter int STABLE_W    = 16,
  parameter int DEF_STABLE  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                lpClk,
  input  logic                rstN,
  input  logic                pdGo,
  input  logic                sbGo,
  input  logic [ALARM_W-1:0]  alarmDelay,
  input  logic [STABLE_W-1:0] stableTicks,
  input  logic                wakeEnable,
  input  logic                coreIdle,
  input  logic                extWake,
  input  logic                irq,
  input  logic                clrCause,
  input  pdcStrobe_t          strb,
  output logic                reqBusy,
  output logic                newReq,
  output logic                reqStandby,
  output logic                idleS,
  output logic                extS,
  output logic                wenS,
  output logic                irqS,
  output logic                alarmOn,
  output logic                alarmHit,
  output logic                stableDone,
  output logic                causeAlarm,
  output logic                causeExt
);
  localparam logic [STABLE_W-1:0] DEF_LEN = STABLE_W'(DEF_STABLE);
  localparam int NSYNC = 6;

  // ---- core-clock side: capture and toggle ----
  logic                reqTgl, ackS, heldStandby;
  logic [ALARM_W-1:0]  heldDelay;
  logic [STABLE_W-1:0] heldStable;
  logic                accept;

  assign reqBusy = reqTgl ^ ackS;
  assign accept  = (pdGo | sbGo) & ~reqBusy;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      reqTgl      <= 1'b0;
      heldStandby <= 1'b0;
      heldDelay   <= '0;
      heldStable  <= '0;
    end else if (accept) begin
      reqTgl      <= ~reqTgl;
      heldStandby <= ~pdGo;
      heldDelay   <= alarmDelay;
      heldStable  <= stableTicks;
    end
  end

  // ---- slow-clock side: synchronisers ----
  logic reqTglS, clrS, reqSeen;
  logic [NSYNC-1:0] syncOut;

  pdc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) uLpSync (
    .clk (lpClk), .rstN (rstN),
    .d   ({reqTgl, coreIdle, extWake, wakeEnable, irq, clrCause}),
    .q   (syncOut)
  );
  assign {reqTglS, idleS, extS, wenS, irqS, clrS} = syncOut;

  pdc_sync #(.W(1), .STAGES(SYNC_STAGES)) uAckSync (
    .clk (sysClk), .rstN (rstN), .d (reqSeen), .q (ackS)
  );

  assign newReq     = reqTglS ^ reqSeen;
  assign reqStandby = heldStandby;

  // ---- slow-clock side: counters and cause bits ----
  logic [ALARM_W-1:0]  alarmCnt;
  logic [STABLE_W-1:0] stableLen, stableCnt;

  always_ff @(posedge lpClk or negedge rstN) begin
    if (!rstN) begin
      reqSeen    <= 1'b0;
      alarmCnt   <= '0;
      alarmOn    <= 1'b0;
      stableLen  <= DEF_LEN;
      stableCnt  <= '0;
      causeAlarm <= 1'b0;
      causeExt   <= 1'b0;
    end else begin
      reqSeen <= reqTglS;
      if (strb.loadAll) begin
        alarmCnt  <= heldDelay;
        alarmOn   <= |heldDelay;
        stableLen <= (heldStable == '0) ? DEF_LEN : heldStable;
      end else if (strb.decAlarm) begin
        alarmCnt <= alarmCnt - 1'b1;
      end
      if (strb.loadStable)     stableCnt <= stableLen;
      else if (strb.decStable) stableCnt <= stableCnt - 1'b1;
      if (strb.setAlarm)  causeAlarm <= 1'b1;
      else if (clrS)      causeAlarm <= 1'b0;
      if (strb.setExt)    causeExt   <= 1'b1;
      else if (clrS)      causeExt   <= 1'b0;
    end
  end

  assign alarmHit   = alarmOn && (alarmCnt == ALARM_W'(1));
  assign stableDone = (stableCnt == STABLE_W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge lpClk) disable iff (!rstN)
    strb.decAlarm |-> (alarmCnt > ALARM_W'(1))); // R2
  AST_STABLE_NO_UNDERFLOW: assert property (@(posedge lpClk) disable iff (!rstN)
    strb.decStable |-> (stableCnt > STABLE_W'(1))); // R2
  AST_HELD_STABLE: assert property (@(posedge sysClk) disable iff (!rstN)
    reqBusy |=> $stable(heldDelay)); // R9
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
(
  input  logic       lpClk,
  input  logic       rstN,
  input  logic       irq,
  input  logic       newReq,
  input  logic       reqStandby,
  input  logic       idleS,
  input  logic       extS,
  input  logic       wenS,
  input  logic       irqS,
  input  logic       alarmOn,
  input  logic       alarmHit,
  input  logic       stableDone,
  output pdcStrobe_t strb,
  output logic       clkEn,
  output logic       oscEn,
  output logic       cpuHalt
);
  pwrState_e state, nextState;
  logic extHit;

  assign extHit = extS & wenS;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_RUN: if (newReq) begin
        if (reqStandby) nextState = ST_STANDBY;
        else begin
          nextState    = ST_ENTER_PD;
          strb.loadAll = 1'b1;
        end
      end
      ST_STANDBY:  if (irqS)  nextState = ST_RUN;
      ST_ENTER_PD: if (idleS) nextState = ST_POWERDOWN;
      ST_POWERDOWN: begin
        if (alarmHit || extHit) begin
          nextState       = ST_WAIT_STABLE;
          strb.loadStable = 1'b1;
          strb.setAlarm   = alarmHit;
          strb.setExt     = extHit;
        end else if (alarmOn) begin
          strb.decAlarm = 1'b1;
        end
      end
      ST_WAIT_STABLE: begin
        if (stableDone) nextState = ST_RUN;
        else            strb.decStable = 1'b1;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge lpClk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  assign clkEn   = (state == ST_RUN) || (state == ST_STANDBY) || (state == ST_ENTER_PD);
  assign oscEn   = (state != ST_POWERDOWN);
  assign cpuHalt = (state == ST_STANDBY) && !irq;

  AST_GATE_AFTER_IDLE: assert property (@(posedge lpClk) disable iff (!rstN)
    $fell(clkEn) |-> $past(idleS)); // R3
  AST_HOLD_WHILE_BUSY: assert property (@(posedge lpClk) disable iff (!rstN)
    (state == ST_ENTER_PD && !idleS) |=> (state == ST_ENTER_PD)); // R3
  AST_RELEASE_AFTER_WAIT: assert property (@(posedge lpClk) disable iff (!rstN)
    $rose(clkEn) |-> $past(stableDone)); // R2
  AST_NO_SPURIOUS_WAKE: assert property (@(posedge lpClk) disable iff (!rstN)
    (state == ST_POWERDOWN && !alarmHit && !extHit) |=> !oscEn); // R4
  AST_HALT_CLOCKS_ON: assert property (@(posedge lpClk) disable iff (!rstN)
    cpuHalt |-> (clkEn && oscEn)); // R8
endmodule

// File: rtl/pdc_top.sv
module pdc_top
  import pdc_pkg::*;
#(
  parameter int ALARM_W     = 32,
  parameter int STABLE_W    = 16,
  parameter int DEF_STABLE  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                lpClk,
  input  logic                rstN,
  input  logic                pdGo,
  input  logic                sbGo,
  input  logic [ALARM_W-1:0]  alarmDelay,
  input  logic [STABLE_W-1:0] stableTicks,
  input  logic                wakeEnable,
  input  logic                coreIdle,
  input  logic                extWake,
  input  logic                irq,
  input  logic                clrCause,
  output logic                reqBusy,
  output logic                clkEn,
  output logic                oscEn,
  output logic                cpuHalt,
  output logic                causeAlarm,
  output logic                causeExt
);
  pdcStrobe_t strb;
  logic newReq, reqStandby, idleS, extS, wenS, irqS;
  logic alarmOn, alarmHit, stableDone;

  pdc_datapath #(
    .ALARM_W(ALARM_W), .STABLE_W(STABLE_W),
    .DEF_STABLE(DEF_STABLE), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .sysClk, .lpClk, .rstN, .pdGo, .sbGo, .alarmDelay, .stableTicks,
    .wakeEnable, .coreIdle, .extWake, .irq, .clrCause, .strb,
    .reqBusy, .newReq, .reqStandby, .idleS, .extS, .wenS, .irqS,
    .alarmOn, .alarmHit, .stableDone, .causeAlarm, .causeExt
  );

  pdc_ctrl uCtrl (
    .lpClk, .rstN, .irq, .newReq, .reqStandby, .idleS, .extS, .wenS,
    .irqS, .alarmOn, .alarmHit, .stableDone, .strb,
    .clkEn, .oscEn, .cpuHalt
  );
endmodule

// File: tb/tb_pdc_top.sv
module tb_pdc_top;
  localparam int SYS_PERIOD = 10;
  localparam int LP_PERIOD  = 70;
  localparam int DEF_STAB   = 1024;

  logic sysClk = 1'b0, lpClk = 1'b0, rstN = 1'b0;
  logic pdGo = 0, sbGo = 0, wakeEnable = 0, coreIdle = 1, extWake = 0, irq = 0, clrCause = 0;
  logic [31:0] alarmDelay = '0;
  logic [15:0] stableTicks = '0;
  logic reqBusy, clkEn, oscEn, cpuHalt, causeAlarm, causeExt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(SYS_PERIOD/2) sysClk = ~sysClk;
  always #(LP_PERIOD/2)  lpClk  = ~lpClk;

  pdc_top dut (.*);

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lpWait(input int n);
    repeat (n) @(negedge lpClk);
  endtask

  task automatic measure(output int clkLow, output int oscLow);
    bit started = 0;
    clkLow = 0; oscLow = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge lpClk);
      if (!clkEn) begin
        started = 1; clkLow++;
        if (!oscEn) oscLow++;
      end else if (started) break;
    end
  endtask

  task automatic issue(input int d, input int s);
    while (reqBusy) @(negedge sysClk);
    @(negedge sysClk);
    alarmDelay = d; stableTicks = s; pdGo = 1;
    @(negedge sysClk);
    pdGo = 0;
  endtask

  task automatic clearCause();
    clrCause = 1; lpWait(5); clrCause = 0; lpWait(4);
  endtask

  initial begin
    #(LP_PERIOD * 200000 / 7 / 3);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cl, ol;
    #(LP_PERIOD * 2 + 3);
    @(negedge sysClk);
    check("R1 clkEn", clkEn, 1);
    check("R1 oscEn", oscEn, 1);
    check("R1 cpuHalt", cpuHalt, 0);
    check("R1 causeAlarm", causeAlarm, 0);
    check("R1 causeExt", causeExt, 0);
    check("R1 reqBusy", reqBusy, 0);
    rstN = 1;
    lpWait(3);

    // R2 sweep over alarm delay and stabilisation length
    for (int d = 1; d <= 6; d++)
      for (int s = 1; s <= 4; s++) begin
        issue(d, s);
        measure(cl, ol);
        check($sformatf("R2 osc low d=%0d s=%0d", d, s), ol, d);
        check($sformatf("R2 clk low d=%0d s=%0d", d, s), cl, d + s);
      end
    lpWait(3);
    check("R6 causeAlarm sticky", causeAlarm, 1);
    check("R6 causeExt clear", causeExt, 0);
    clearCause();
    check("R6 causeAlarm cleared", causeAlarm, 0);

    // R5 external wake disabled
    wakeEnable = 0;
    issue(7, 2);
    fork
      measure(cl, ol);
      begin
        wait (clkEn == 0);
        lpWait(2); extWake = 1; lpWait(3); extWake = 0;
      end
    join
    check("R5 osc low unchanged", ol, 7);
    check("R5 causeExt", causeExt, 0);
    check("R5 causeAlarm", causeAlarm, 1);
    clearCause();

    // R3 deferral while busy
    coreIdle = 0;
    issue(4, 3);
    lpWait(20);
    check("R3 clkEn held", clkEn, 1);
    check("R3 oscEn held", oscEn, 1);
    coreIdle = 1;
    measure(cl, ol);
    check("R3 osc low after idle", ol, 4);
    check("R3 clk low after idle", cl, 7);

    // R7 default stabilisation length
    issue(2, 0);
    measure(cl, ol);
    check("R7 osc low", ol, 2);
    check("R7 clk low default", cl, 2 + DEF_STAB);

    // R9 second request while busy ignored
    while (reqBusy) @(negedge sysClk);
    @(negedge sysClk);
    alarmDelay = 3; stableTicks = 2; pdGo = 1;
    @(negedge sysClk);
    check("R9 busy after accept", reqBusy, 1);
    alarmDelay = 9;
    @(negedge sysClk);
    pdGo = 0;
    measure(cl, ol);
    check("R9 osc low first delay", ol, 3);
    check("R9 clk low first delay", cl, 5);
    lpWait(4);
    check("R9 busy released", reqBusy, 0);
    clearCause();

    // R4 alarm off, external wake
    wakeEnable = 1;
    lpWait(4);
    issue(0, 3);
    fork
      measure(cl, ol);
      begin
        wait (clkEn == 0);
        lpWait(6); extWake = 1;
        wait (clkEn == 1); extWake = 0;
      end
    join
    check("R4 stayed down past start", (ol >= 6) ? 1 : 0, 1);
    check("R4 stabilise after ext", cl - ol, 3);
    check("R4 causeExt", causeExt, 1);
    check("R4 causeAlarm", causeAlarm, 0);
    clearCause();
    check("R6 causeExt cleared", causeExt, 0);

    // R8 standby
    @(negedge sysClk);
    sbGo = 1;
    @(negedge sysClk);
    sbGo = 0;
    lpWait(6);
    check("R8 halt in standby", cpuHalt, 1);
    check("R8 clk on in standby", clkEn, 1);
    check("R8 osc on in standby", oscEn, 1);
    irq = 1;
    #1;
    check("R8 halt drops at irq", cpuHalt, 0);
    lpWait(6);
    irq = 0;
    lpWait(2);
    check("R8 run after standby", cpuHalt, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule